// File: doc/BRIEF.md
# Scalar Point Multiplier Register Front End

This block sits between a 32-bit memory-mapped bus and a 256-bit elliptic-curve scalar point multiplication engine. Software loads a scalar and the two affine coordinates of an input point, word by word. It then sets a command bit to launch one multiplication and polls a status flag until the result is ready. After that it reads the two result coordinates back word by word. The point arithmetic belongs to the engine, which is outside this block.

The bus uses one transfer per cycle: a select, a write enable, a word address and write data. Read data is combinational from the address while a read is selected and is zero otherwise. The engine port is parallel. It carries a one-cycle start pulse, three operand vectors, a done strobe, and two result vectors that are sampled while done is high.

Top module: `ecm_regfront`

## Requirements
- R1: After reset the command bit is 0, the completion flag is 0, and every operand and result word reads 0. No start pulse is issued.
- R2: The identification words are read-only. Word address 0x00 reads 32'h65636468, 0x01 reads 32'h70323536 and 0x02 reads 32'h302E3130 (ASCII with the first character in bits [31:24]).
- R3: Scalar words sit at word addresses 0x40–0x47, X words at 0x48–0x4F and Y words at 0x50–0x57. Word i of each region is bits [32i+31:32i] of the matching 256-bit engine operand. These words read back as written.
- R4: The command word at 0x08 stores only bit 1 (go). Every other bit reads 0.
- R5: A start pulse exactly one cycle wide is sent to the engine in the cycle after a command write moves go from 0 to 1. Writing go=1 while it is already 1 starts nothing, so go must be cleared before the next start.
- R6: The completion flag (status bit 1) is 0 from the cycle the start pulse is issued. It becomes 1 two cycles after the cycle in which the engine raises done.
- R7: On the cycle done is high, the result buffers capture the engine results. These are readable at word addresses 0x58–0x5F (X) and 0x60–0x67 (Y), in the same word order as R3. At all other times the result buffers ignore the engine result lines.
- R8: Writes to identification, status, result or unmapped addresses change nothing. Reads of unmapped addresses return 0.
- R9: The status word at 0x09 always has bit 0 (ready) at 1 and bits [31:2] at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Transfer select |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (8) | Word address |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, 0 when no read is selected |
| eng_start | output | 1 | One-cycle launch pulse to the engine |
| eng_done | input | 1 | Engine result strobe |
| eng_k | output | OPW (256) | Scalar operand |
| eng_x | output | OPW (256) | Input point X |
| eng_y | output | OPW (256) | Input point Y |
| eng_rx | input | OPW (256) | Result point X |
| eng_ry | input | OPW (256) | Result point Y |

## Verification
A corrupted go register shows up in two ways. It either sends an extra start pulse on a repeated command write, or it sends none after a clear-and-set. Either fault can be seen at eng_start one cycle after the write. A stuck or mistimed completion flag shows in the first status read after the launch, or two cycles after done. Result capture that is not gated by done leaves words that are the inverse of the true result, because the bench engine drives inverted data outside its strobe. A full address sweep then exposes these words, as it does any word-select or region-decode fault.

// File: rtl/ecm_rf_pkg.sv
package ecm_rf_pkg;
   localparam int WA_ID_HI = 'h00;
   localparam int WA_ID_LO = 'h01;
   localparam int WA_REV   = 'h02;
   localparam int WA_CMD   = 'h08;
   localparam int WA_STAT  = 'h09;

   localparam int N_OPER = 3;
   localparam int N_RES  = 2;
   localparam int OPER_BASE [N_OPER] = '{'h40, 'h48, 'h50};
   localparam int RES_BASE  [N_RES]  = '{'h58, 'h60};

   localparam logic [31:0] ID_HI = 32'h6563_6468;
   localparam logic [31:0] ID_LO = 32'h7032_3536;
   localparam logic [31:0] REV   = 32'h302E_3130;

   localparam int CMD_GO_BIT    = 1;
   localparam int STAT_RDY_BIT  = 0;
   localparam int STAT_DONE_BIT = 1;
endpackage

// File: rtl/ecm_word_bank.sv
module ecm_word_bank #(
   parameter int DW    = 32,
   parameter int WORDS = 8,
   localparam int IW   = $clog2(WORDS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IW-1:0]      idx,
   input  logic [DW-1:0]      wr_data,
   output logic [DW-1:0]      rd_data,
   output logic [DW*WORDS-1:0] par_out
);
   logic [WORDS-1:0][DW-1:0] mem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mem_q <= '0;
      else if (wr_en) mem_q[idx] <= wr_data;
   end

   assign rd_data = mem_q[idx];
   assign par_out = mem_q;
endmodule

// File: rtl/ecm_result_bank.sv
module ecm_result_bank #(
   parameter int DW    = 32,
   parameter int WORDS = 8,
   localparam int IW   = $clog2(WORDS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cap_en,
   input  logic [DW*WORDS-1:0] par_in,
   input  logic [IW-1:0]       idx,
   output logic [DW-1:0]       rd_data
);
   logic [WORDS-1:0][DW-1:0] mem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mem_q <= '0;
      else if (cap_en) mem_q <= par_in;
   end

   assign rd_data = mem_q[idx];
endmodule

// File: rtl/ecm_start_gen.sv
module ecm_start_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_wr,
   input  logic cmd_go,
   output logic go_q,
   output logic launch,
   output logic start_q
);
   assign launch = cmd_wr && cmd_go && !go_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         go_q    <= 1'b0;
         start_q <= 1'b0;
      end else begin
         if (cmd_wr) go_q <= cmd_go;
         start_q <= launch;
      end
   end
endmodule

// File: rtl/ecm_regfront.sv
module ecm_regfront
   import ecm_rf_pkg::*;
#(
   parameter int DW  = 32,
   parameter int OPW = 256,
   parameter int AW  = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           bus_cs,
   input  logic           bus_we,
   input  logic [AW-1:0]  bus_addr,
   input  logic [DW-1:0]  bus_wdata,
   output logic [DW-1:0]  bus_rdata,
   output logic           eng_start,
   input  logic           eng_done,
   output logic [OPW-1:0] eng_k,
   output logic [OPW-1:0] eng_x,
   output logic [OPW-1:0] eng_y,
   input  logic [OPW-1:0] eng_rx,
   input  logic [OPW-1:0] eng_ry
);
   localparam int WORDS = OPW / DW;
   localparam int IW    = $clog2(WORDS);

   if (OPW % DW != 0) begin : g_bad_ratio
      $error("OPW must be a multiple of DW");
   end
   if ((1 << IW) != WORDS) begin : g_bad_words
      $error("OPW/DW must be a power of two");
   end
   if (DW < 32) begin : g_bad_dw
      $error("DW must hold the 32-bit identification words");
   end
   if (AW < 7) begin : g_bad_aw
      $error("AW too small for the register map");
   end

   logic          wr, rd;
   logic [IW-1:0] idx;
   assign wr  = bus_cs && bus_we;
   assign rd  = bus_cs && !bus_we;
   assign idx = bus_addr[IW-1:0];

   logic [N_OPER-1:0] op_sel;
   logic [DW-1:0]     op_rd  [N_OPER];
   logic [OPW-1:0]    op_par [N_OPER];

   for (genvar g = 0; g < N_OPER; g++) begin : g_oper
      if (OPER_BASE[g] % WORDS != 0) begin : g_align
         $error("operand region not aligned");
      end
      assign op_sel[g] = (bus_addr >> IW) == AW'(OPER_BASE[g] >> IW);
      ecm_word_bank #(.DW(DW), .WORDS(WORDS)) u_bank (
         .clk(clk), .rst_n(rst_n),
         .wr_en(wr && op_sel[g]), .idx(idx), .wr_data(bus_wdata),
         .rd_data(op_rd[g]), .par_out(op_par[g])
      );
   end

   assign eng_k = op_par[0];
   assign eng_x = op_par[1];
   assign eng_y = op_par[2];

   logic [N_RES-1:0] res_sel;
   logic [DW-1:0]    res_rd [N_RES];
   logic [OPW-1:0]   res_in [N_RES];
   assign res_in[0] = eng_rx;
   assign res_in[1] = eng_ry;

   for (genvar r = 0; r < N_RES; r++) begin : g_res
      if (RES_BASE[r] % WORDS != 0) begin : g_align
         $error("result region not aligned");
      end
      assign res_sel[r] = (bus_addr >> IW) == AW'(RES_BASE[r] >> IW);
      ecm_result_bank #(.DW(DW), .WORDS(WORDS)) u_bank (
         .clk(clk), .rst_n(rst_n),
         .cap_en(eng_done), .par_in(res_in[r]), .idx(idx),
         .rd_data(res_rd[r])
      );
   end

   logic go_q, launch;
   ecm_start_gen u_start (
      .clk(clk), .rst_n(rst_n),
      .cmd_wr(wr && bus_addr == AW'(WA_CMD)),
      .cmd_go(bus_wdata[CMD_GO_BIT]),
      .go_q(go_q), .launch(launch), .start_q(eng_start)
   );

   logic done_d, valid_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_d  <= 1'b0;
         valid_q <= 1'b0;
      end else begin
         done_d <= eng_done;
         if (launch)      valid_q <= 1'b0;
         else if (done_d) valid_q <= 1'b1;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (rd) begin
         case (bus_addr)
            AW'(WA_ID_HI): bus_rdata = DW'(ID_HI);
            AW'(WA_ID_LO): bus_rdata = DW'(ID_LO);
            AW'(WA_REV):   bus_rdata = DW'(REV);
            AW'(WA_CMD):   bus_rdata[CMD_GO_BIT] = go_q;
            AW'(WA_STAT): begin
               bus_rdata[STAT_RDY_BIT]  = 1'b1;
               bus_rdata[STAT_DONE_BIT] = valid_q;
            end
            default: ;
         endcase
         for (int g = 0; g < N_OPER; g++)
            if (op_sel[g]) bus_rdata = op_rd[g];
         for (int r = 0; r < N_RES; r++)
            if (res_sel[r]) bus_rdata = res_rd[r];
      end
   end
endmodule

// File: rtl/ecm_regfront_chk.sv
module ecm_regfront_chk #(
   parameter int DW = 32,
   parameter int AW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_cs,
   input logic          bus_we,
   input logic [AW-1:0] bus_addr,
   input logic [DW-1:0] bus_rdata,
   input logic          eng_start,
   input logic          eng_done,
   input logic          go_q,
   input logic          valid_q
);
   p_start_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |=> !eng_start);

   p_start_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> (go_q && !$past(go_q)));

   p_start_clears_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> !valid_q);

   p_flag_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid_q) |-> $past(eng_done, 2));

   p_status_fixed_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cs && !bus_we && bus_addr == AW'(9)) |->
         (bus_rdata[0] && bus_rdata[DW-1:2] == '0));

   p_cmd_readback_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cs && !bus_we && bus_addr == AW'(8)) |->
         (bus_rdata[1] == go_q && bus_rdata[0] == 1'b0 && bus_rdata[DW-1:2] == '0));
endmodule

bind ecm_regfront ecm_regfront_chk #(.DW(DW), .AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
   .bus_addr(bus_addr), .bus_rdata(bus_rdata), .eng_start(eng_start),
   .eng_done(eng_done), .go_q(go_q), .valid_q(valid_q)
);

// File: tb/test_ecm_regfront.sv
module test_ecm_regfront;
   localparam int PERIOD = 10;
   localparam int LAT    = 6;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_cs = 1'b0, bus_we = 1'b0;
   logic [7:0]   bus_addr = '0;
   logic [31:0]  bus_wdata = '0;
   logic [31:0]  bus_rdata;
   logic         eng_start;
   logic         eng_done;
   logic [255:0] eng_k, eng_x, eng_y, eng_rx, eng_ry;

   always #(PERIOD/2) clk = ~clk;

   ecm_regfront i_ecm_regfront (
      .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .eng_start(eng_start), .eng_done(eng_done),
      .eng_k(eng_k), .eng_x(eng_x), .eng_y(eng_y),
      .eng_rx(eng_rx), .eng_ry(eng_ry)
   );

   // behavioural engine: fixed latency, results valid only while done is high
   logic     busy;
   int       cnt;
   int       starts;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eng_done <= 1'b0; busy <= 1'b0; cnt <= 0; starts <= 0;
      end else begin
         eng_done <= 1'b0;
         if (eng_start) begin
            busy <= 1'b1; cnt <= 0; starts <= starts + 1;
         end else if (busy) begin
            if (cnt == LAT-1) begin busy <= 1'b0; eng_done <= 1'b1; end
            else cnt <= cnt + 1;
         end
      end
   end
   assign eng_rx = eng_done ? (eng_k + eng_x) : ~(eng_k + eng_x);
   assign eng_ry = eng_done ? (eng_k ^ eng_y) : ~(eng_k ^ eng_y);

   // bench model
   logic [255:0] m_k = '0, m_x = '0, m_y = '0, m_rx = '0, m_ry = '0;
   logic         m_go = 1'b0, m_valid = 1'b0;
   int           n_chk = 0, n_fail = 0;
   bit           finished = 0;

   function automatic logic [31:0] exp_rd(int a);
      if (a == 0) return 32'h6563_6468;
      if (a == 1) return 32'h7032_3536;
      if (a == 2) return 32'h302E_3130;
      if (a == 8) return {30'd0, m_go, 1'b0};
      if (a == 9) return {30'd0, m_valid, 1'b1};
      if (a >= 'h40 && a < 'h48) return m_k[(a-'h40)*32 +: 32];
      if (a >= 'h48 && a < 'h50) return m_x[(a-'h48)*32 +: 32];
      if (a >= 'h50 && a < 'h58) return m_y[(a-'h50)*32 +: 32];
      if (a >= 'h58 && a < 'h60) return m_rx[(a-'h58)*32 +: 32];
      if (a >= 'h60 && a < 'h68) return m_ry[(a-'h60)*32 +: 32];
      return 32'd0;
   endfunction

   function automatic string tag_of(int a);
      if (a < 3) return "R2";
      if (a == 8) return "R4";
      if (a == 9) return "R9";
      if (a >= 'h40 && a < 'h58) return "R3";
      if (a >= 'h58 && a < 'h68) return "R7";
      return "R8";
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [255:0] act, input logic [255:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic bus_wr(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_cs = 1'b1; bus_we = 1'b1; bus_addr = a[7:0]; bus_wdata = d;
      @(negedge clk);
      bus_cs = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_rd(input int a, output logic [31:0] d);
      @(negedge clk);
      bus_cs = 1'b1; bus_we = 1'b0; bus_addr = a[7:0];
      #1 d = bus_rdata;
   endtask

   task automatic sweep(input string phase);
      logic [31:0] v;
      for (int a = 0; a < 256; a++) begin
         bus_rd(a, v);
         check(v === exp_rd(a), tag_of(a), $sformatf("%s addr %02h", phase, a),
               256'(v), 256'(exp_rd(a)));
      end
      bus_cs = 1'b0;
   endtask

   task automatic load_operands(input logic [31:0] seed);
      for (int g = 0; g < 3; g++)
         for (int i = 0; i < 8; i++) begin
            logic [31:0] w = seed ^ (32'(g) << 28) ^ (32'(i) * 32'h0101_0107);
            bus_wr('h40 + g*8 + i, w);
            if (g == 0) m_k[i*32 +: 32] = w;
            if (g == 1) m_x[i*32 +: 32] = w;
            if (g == 2) m_y[i*32 +: 32] = w;
         end
      check(eng_k === m_k, "R3", "scalar operand port", eng_k, m_k);
      check(eng_x === m_x, "R3", "X operand port", eng_x, m_x);
      check(eng_y === m_y, "R3", "Y operand port", eng_y, m_y);
   endtask

   task automatic launch_and_wait(input int exp_starts);
      logic [31:0] v;
      bit seen;
      bus_wr(8, 32'hFFFF_FFFF);
      m_go = 1'b1;
      check(eng_start === 1'b1, "R5", "start pulse after go rise", 256'(eng_start), 256'(1));
      bus_rd(9, v);
      check(eng_start === 1'b0, "R5", "start pulse one cycle wide", 256'(eng_start), 256'(0));
      check(v[1] === 1'b0, "R6", "flag low once running", 256'(v[1]), 256'(0));
      seen = 0;
      for (int t = 0; t < 40 && !seen; t++) begin
         bus_rd(9, v);
         if (eng_done) begin
            check(v[1] === 1'b0, "R6", "flag still low during done", 256'(v[1]), 256'(0));
         end
         if (v[1]) seen = 1;
      end
      bus_cs = 1'b0;
      check(seen, "R6", "flag rises after done", 256'(seen), 256'(1));
      check(starts == exp_starts, "R5", "start count", 256'(starts), 256'(exp_starts));
      m_rx = m_k + m_x; m_ry = m_k ^ m_y; m_valid = 1'b1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check(eng_start === 1'b0, "R1", "no start after reset", 256'(eng_start), 256'(0));
      sweep("R1 reset");

      load_operands(32'hA5C3_1E70);
      sweep("after load");

      launch_and_wait(1);
      sweep("after first op");

      // R5: go already 1, writing it again starts nothing
      bus_wr(8, 32'h0000_0002);
      repeat (LAT + 4) @(negedge clk);
      check(starts == 1, "R5", "no start while go held", 256'(starts), 256'(1));
      sweep("go held");

      // R8: writes to read-only and unmapped words change nothing
      for (int a = 0; a < 256; a++)
         if (a != 8 && !(a >= 'h40 && a < 'h58)) bus_wr(a, 32'hFFFF_FFFF);
      check(starts == 1, "R8", "no start from ignored writes", 256'(starts), 256'(1));
      sweep("R8 after ignored writes");

      // clear then set: second operation with new operands
      bus_wr(8, 32'h0);
      m_go = 1'b0;
      check(starts == 1, "R5", "no start on clear", 256'(starts), 256'(1));
      load_operands(32'h1234_FEDC);
      launch_and_wait(2);
      sweep("after second op");

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(PERIOD * 150000);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule